// File: doc/BRIEF.md
# DMA Minor-Loop Address Update Unit

This unit sits in the descriptor write-back path of a DMA channel engine. Each minor loop of a transfer ends with a strobe. On that strobe the unit does three things. It reads the 32-bit byte-count word of the descriptor. It works out how many bytes the descriptor asks for. It computes the source and destination addresses that are written back into the descriptor for the next iteration.

A mode bit selects how the byte-count word is read. With the mode bit clear, the whole word is a byte count. With the mode bit set, the upper two bits are per-direction enables, and a signed offset sits below them. That one offset can move the source address, the destination address, or both, between minor loops. When the major loop has finished, the offset no longer applies. Each address then takes its own last-address adjustment instead.

All results are registered. A one-cycle write-back strobe marks them valid, one clock after the minor-loop strobe. Between strobes the outputs keep their values.

Top module: `ml_addr_update`

## Requirements
- R1: While rst_n is low, byte_cnt, src_next and dst_next read zero and wb_strobe is low.
- R2: With map_en low, byte_cnt takes all 32 bits of desc_word.
- R3: With map_en high and desc_word bits 31 and 30 both clear, byte_cnt is desc_word[29:0], zero-extended to 32 bits.
- R4: With map_en high and desc_word bit 31 or bit 30 set, byte_cnt is desc_word[9:0], zero-extended to 32 bits.
- R5: With map_en high, major_done low and desc_word bit 31 (source enable) set, src_next = src_final + sign-extended desc_word[29:10]. With bit 31 clear, src_next = src_final.
- R6: With map_en high, major_done low and desc_word bit 30 (destination enable) set, dst_next = dst_final + the same sign-extended desc_word[29:10]. With bit 30 clear, dst_next = dst_final.
- R7: With map_en low and major_done low, src_next = src_final and dst_next = dst_final, whatever desc_word holds.
- R8: With major_done high, src_next = src_final + src_last_adj and dst_next = dst_final + dst_last_adj. The mapped offset and its enables have no effect.
- R9: wb_strobe is high for exactly the cycles that follow a cycle with minor_done high. After a cycle with minor_done low, byte_cnt, src_next and dst_next keep their values.
- R10: All address sums wrap modulo 2^32, including negative offsets that pass below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_en | input | 1 | Selects the mapped layout of the byte-count word |
| desc_word | input | 32 | Byte-count word of the descriptor |
| src_final | input | 32 | Source address at the end of the minor loop |
| dst_final | input | 32 | Destination address at the end of the minor loop |
| minor_done | input | 1 | Minor loop finished this cycle |
| major_done | input | 1 | The finishing minor loop also ends the major loop |
| src_last_adj | input | 32 | Source adjustment applied at major-loop end |
| dst_last_adj | input | 32 | Destination adjustment applied at major-loop end |
| byte_cnt | output | 32 | Decoded byte count |
| src_next | output | 32 | Source address to write back |
| dst_next | output | 32 | Destination address to write back |
| wb_strobe | output | 1 | One-cycle write-back valid pulse |

## Verification
The hardest case to reach is a minor-loop strobe that arrives with major_done high while the mapped word holds both enables and a large negative offset. In that case the offset must have no effect, and only the last-address sums may move the addresses. The stimulus builds this case on purpose. It also builds the same word with major_done low, with the final addresses near zero, so that the offset path wraps below zero. Back-to-back strobes and idle gaps with changing inputs are mixed into a long random phase. That phase shows that the outputs hold between pulses and that the strobe never lasts longer than one cycle.

// File: rtl/ml_upd_pkg.sv
package ml_upd_pkg;
  localparam int unsigned DESC_W      = 32;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned SHORT_CNT_W = 10;
  localparam int unsigned OFF_W       = 20;
  localparam int unsigned SRC_EN_BIT  = DESC_W - 1;
  localparam int unsigned DST_EN_BIT  = DESC_W - 2;
  localparam int unsigned LONG_CNT_W  = DESC_W - 2;
  localparam int unsigned OFF_LSB     = SHORT_CNT_W;
  localparam int unsigned OFF_MSB     = OFF_LSB + OFF_W - 1;
  localparam int unsigned NUM_DIR     = 2;

  typedef enum logic [1:0] {
    LAYOUT_FLAT  = 2'd0,
    LAYOUT_LONG  = 2'd1,
    LAYOUT_SHORT = 2'd2
  } layout_e;

  typedef struct packed {
    layout_e            layout;
    logic               src_off_en;
    logic               dst_off_en;
    logic [ADDR_W-1:0]  offset;
    logic [DESC_W-1:0]  count;
  } desc_fields_t;

  // Sign-extend the raw offset field to address width.
  function automatic logic [ADDR_W-1:0] widen_offset(input logic [OFF_W-1:0] raw);
    return {{(ADDR_W-OFF_W){raw[OFF_W-1]}}, raw};
  endfunction

  // Modulo 2^ADDR_W addition.
  function automatic logic [ADDR_W-1:0] wrap_add(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] b);
    return a + b;
  endfunction

  // Zero-extend the low n bits of a descriptor word.
  function automatic logic [DESC_W-1:0] keep_low(input logic [DESC_W-1:0] w,
                                                 input int unsigned n);
    logic [DESC_W-1:0] mask;
    mask = '0;
    for (int unsigned i = 0; i < DESC_W; i++) begin
      if (i < n) mask[i] = 1'b1;
    end
    return w & mask;
  endfunction
endpackage

// File: rtl/ml_desc_decode.sv
module ml_desc_decode
  import ml_upd_pkg::*;
(
  input  logic               map_en,
  input  logic [DESC_W-1:0]  word,
  output desc_fields_t       fields
);
  logic any_en;
  assign any_en = word[SRC_EN_BIT] | word[DST_EN_BIT];

  always_comb begin
    fields = '0;
    if (!map_en) begin
      fields.layout = LAYOUT_FLAT;
      fields.count  = word;
    end else if (any_en) begin
      fields.layout     = LAYOUT_SHORT;
      fields.src_off_en = word[SRC_EN_BIT];
      fields.dst_off_en = word[DST_EN_BIT];
      fields.offset     = widen_offset(word[OFF_MSB:OFF_LSB]);
      fields.count      = keep_low(word, SHORT_CNT_W);
    end else begin
      fields.layout = LAYOUT_LONG;
      fields.count  = keep_low(word, LONG_CNT_W);
    end
  end
endmodule

// File: rtl/ml_addr_step.sv
module ml_addr_step
  import ml_upd_pkg::*;
(
  input  logic               major_done,
  input  logic               off_en,
  input  logic [ADDR_W-1:0]  final_addr,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [ADDR_W-1:0]  last_adj,
  output logic [ADDR_W-1:0]  next_addr,
  output logic               off_applied,
  output logic               last_applied
);
  assign last_applied = major_done;
  assign off_applied  = !major_done && off_en;

  always_comb begin
    if (last_applied)      next_addr = wrap_add(final_addr, last_adj);
    else if (off_applied)  next_addr = wrap_add(final_addr, offset);
    else                   next_addr = final_addr;
  end
endmodule

// File: rtl/ml_wb_reg.sv
module ml_wb_reg
  import ml_upd_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [DESC_W-1:0]              cnt_in,
  input  logic [NUM_DIR-1:0][ADDR_W-1:0] addr_in,
  output logic [DESC_W-1:0]              cnt_q,
  output logic [NUM_DIR-1:0][ADDR_W-1:0] addr_q,
  output logic                           strobe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      addr_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= load;
      if (load) begin
        cnt_q  <= cnt_in;
        addr_q <= addr_in;
      end
    end
  end
endmodule

// File: rtl/ml_addr_update.sv
module ml_addr_update
  import ml_upd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_en,
  input  logic [DESC_W-1:0]  desc_word,
  input  logic [ADDR_W-1:0]  src_final,
  input  logic [ADDR_W-1:0]  dst_final,
  input  logic               minor_done,
  input  logic               major_done,
  input  logic [ADDR_W-1:0]  src_last_adj,
  input  logic [ADDR_W-1:0]  dst_last_adj,
  output logic [DESC_W-1:0]  byte_cnt,
  output logic [ADDR_W-1:0]  src_next,
  output logic [ADDR_W-1:0]  dst_next,
  output logic               wb_strobe
);
  localparam int unsigned SRC_IDX = 0;
  localparam int unsigned DST_IDX = 1;

  desc_fields_t                   fields;
  logic [NUM_DIR-1:0]             dir_en;
  logic [NUM_DIR-1:0][ADDR_W-1:0] dir_final;
  logic [NUM_DIR-1:0][ADDR_W-1:0] dir_adj;
  logic [NUM_DIR-1:0][ADDR_W-1:0] dir_next;
  logic [NUM_DIR-1:0][ADDR_W-1:0] dir_q;
  logic [NUM_DIR-1:0]             dir_off_used;
  logic [NUM_DIR-1:0]             dir_last_used;

  ml_desc_decode u_dec (
    .map_en (map_en),
    .word   (desc_word),
    .fields (fields)
  );

  assign dir_en[SRC_IDX]    = fields.src_off_en;
  assign dir_en[DST_IDX]    = fields.dst_off_en;
  assign dir_final[SRC_IDX] = src_final;
  assign dir_final[DST_IDX] = dst_final;
  assign dir_adj[SRC_IDX]   = src_last_adj;
  assign dir_adj[DST_IDX]   = dst_last_adj;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    ml_addr_step u_step (
      .major_done   (major_done),
      .off_en       (dir_en[g]),
      .final_addr   (dir_final[g]),
      .offset       (fields.offset),
      .last_adj     (dir_adj[g]),
      .next_addr    (dir_next[g]),
      .off_applied  (dir_off_used[g]),
      .last_applied (dir_last_used[g])
    );
  end

  ml_wb_reg u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (minor_done),
    .cnt_in   (fields.count),
    .addr_in  (dir_next),
    .cnt_q    (byte_cnt),
    .addr_q   (dir_q),
    .strobe_q (wb_strobe)
  );

  assign src_next = dir_q[SRC_IDX];
  assign dst_next = dir_q[DST_IDX];
endmodule

// File: rtl/ml_upd_checks.sv
module ml_upd_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        map_en,
  input logic [31:0] desc_word,
  input logic [31:0] src_final,
  input logic [31:0] dst_final,
  input logic        minor_done,
  input logic        major_done,
  input logic [31:0] src_last_adj,
  input logic [31:0] dst_last_adj,
  input logic [31:0] byte_cnt,
  input logic [31:0] src_next,
  input logic [31:0] dst_next,
  input logic        wb_strobe
);
  // R9
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |=> wb_strobe);
  // R9
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !minor_done |=> !wb_strobe);
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !minor_done |=> ($stable(src_next) && $stable(dst_next) && $stable(byte_cnt)));
  // R2
  flat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && !map_en) |=> (byte_cnt == $past(desc_word)));
  // R4
  short_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && map_en && (desc_word[31] || desc_word[30])) |=> (byte_cnt[31:10] == 22'd0));
  // R7
  unmapped_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && !map_en && !major_done) |=>
      (src_next == $past(src_final) && dst_next == $past(dst_final)));
  // R8
  major_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && major_done) |=>
      (src_next == 32'($past(src_final) + $past(src_last_adj)) &&
       dst_next == 32'($past(dst_final) + $past(dst_last_adj))));
endmodule

bind ml_addr_update ml_upd_checks u_chk (
  .clk(clk), .rst_n(rst_n), .map_en(map_en), .desc_word(desc_word),
  .src_final(src_final), .dst_final(dst_final), .minor_done(minor_done),
  .major_done(major_done), .src_last_adj(src_last_adj), .dst_last_adj(dst_last_adj),
  .byte_cnt(byte_cnt), .src_next(src_next), .dst_next(dst_next), .wb_strobe(wb_strobe)
);

// File: tb/sim_ml_addr_update.sv
module sim_ml_addr_update;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        map_en = 1'b0;
  logic [31:0] desc_word = '0;
  logic [31:0] src_final = '0;
  logic [31:0] dst_final = '0;
  logic        minor_done = 1'b0;
  logic        major_done = 1'b0;
  logic [31:0] src_last_adj = '0;
  logic [31:0] dst_last_adj = '0;
  logic [31:0] byte_cnt, src_next, dst_next;
  logic        wb_strobe;

  ml_addr_update u0 (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .desc_word(desc_word),
    .src_final(src_final), .dst_final(dst_final), .minor_done(minor_done),
    .major_done(major_done), .src_last_adj(src_last_adj), .dst_last_adj(dst_last_adj),
    .byte_cnt(byte_cnt), .src_next(src_next), .dst_next(dst_next), .wb_strobe(wb_strobe)
  );

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;
  bit compare_on = 0;

  // Reference state
  logic [31:0] m_cnt = '0, m_src = '0, m_dst = '0;
  logic        m_stb = 1'b0;
  string       t_cnt = "R1", t_src = "R1", t_dst = "R1";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural next-address model using wide signed arithmetic
  function automatic longint ref_sum(input logic [31:0] fin, input logic [31:0] adj,
                                     input logic [31:0] w, input bit mp, input bit maj,
                                     input bit en);
    longint base;
    longint off;
    base = longint'(fin);
    if (maj) return base + longint'(adj);
    if (mp && en) begin
      off = longint'(w[29:10]);
      if (off >= 524288) off = off - 1048576;
      return base + off;
    end
    return base;
  endfunction

  function automatic string addr_tag(input string own, input bit mp, input bit maj, input longint s);
    string t;
    if (maj) t = "R8";
    else if (!mp) t = "R7";
    else t = own;
    if (s < 0 || s > 64'hFFFF_FFFF) t = {t, " R10"};
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_src <= '0; m_dst <= '0; m_stb <= 1'b0;
      t_cnt <= "R1"; t_src <= "R1"; t_dst <= "R1";
    end else begin
      m_stb <= minor_done;
      if (minor_done) begin
        longint s;
        longint d;
        s = ref_sum(src_final, src_last_adj, desc_word, map_en, major_done, desc_word[31]);
        d = ref_sum(dst_final, dst_last_adj, desc_word, map_en, major_done, desc_word[30]);
        m_src <= s[31:0];
        m_dst <= d[31:0];
        t_src <= addr_tag("R5", map_en, major_done, s);
        t_dst <= addr_tag("R6", map_en, major_done, d);
        if (!map_en) begin
          m_cnt <= desc_word; t_cnt <= "R2";
        end else if (desc_word[31] || desc_word[30]) begin
          m_cnt <= desc_word % 1024; t_cnt <= "R4";
        end else begin
          m_cnt <= desc_word % 32'h4000_0000; t_cnt <= "R3";
        end
      end else begin
        t_cnt <= "R9 hold"; t_src <= "R9 hold"; t_dst <= "R9 hold";
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on && !done_flag) begin
      check("R9 strobe", {31'd0, wb_strobe}, {31'd0, m_stb});
      check(t_cnt, byte_cnt, m_cnt);
      check(t_src, src_next, m_src);
      check(t_dst, dst_next, m_dst);
    end
  end

  task automatic drive(input bit mp, input logic [31:0] w, input logic [31:0] sf,
                       input logic [31:0] df, input bit dn, input bit mj,
                       input logic [31:0] sa, input logic [31:0] da);
    @(posedge clk);
    #1;
    map_en = mp; desc_word = w; src_final = sf; dst_final = df;
    minor_done = dn; major_done = mj; src_last_adj = sa; dst_last_adj = da;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values on the ports
    check("R1 cnt", byte_cnt, 32'd0);
    check("R1 src", src_next, 32'd0);
    check("R1 dst", dst_next, 32'd0);
    check("R1 strobe", {31'd0, wb_strobe}, 32'd0);
    rst_n = 1'b1;
    compare_on = 1;
    // R2: flat count, offset bits present but unmapped (R7)
    drive(0, 32'hC00F_F3FF, 32'h1000, 32'h2000, 1, 0, 32'h5, 32'h7);
    // R3: long count
    drive(1, 32'h3FFF_FFFF, 32'h1000, 32'h2000, 1, 0, 32'h5, 32'h7);
    drive(0, 32'h0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0);
    // R5 source only, positive offset 0x40, count 0x3C
    drive(1, {2'b10, 20'h00040, 10'h03C}, 32'h1000, 32'h2000, 1, 0, 32'h0, 32'h0);
    // R6 destination only, negative offset -1
    drive(1, {2'b01, 20'hFFFFF, 10'h3FF}, 32'h1000, 32'h2000, 1, 0, 32'h0, 32'h0);
    // R5 R6 R10 both, negative offset wraps below zero
    drive(1, {2'b11, 20'h80000, 10'h001}, 32'h10, 32'h0, 1, 0, 32'h0, 32'h0);
    // R10 positive wrap past top
    drive(1, {2'b11, 20'h7FFFF, 10'h002}, 32'hFFFF_FFF0, 32'hFFFF_0000, 1, 0, 32'h0, 32'h0);
    // R8 major done: offset ignored, last adjustments used
    drive(1, {2'b11, 20'h80000, 10'h004}, 32'h10, 32'h20, 1, 1, 32'hFFFF_FFF0, 32'h100);
    drive(0, 32'h1234, 32'hFFFF_FFFF, 32'h1, 1, 1, 32'h1, 32'hFFFF_FFFF);
    // R9 idle with changing inputs: outputs hold
    drive(1, 32'hFFFF_FFFF, 32'hAAAA, 32'hBBBB, 0, 1, 32'h9, 32'h9);
    drive(0, 32'h0, 32'h1, 32'h2, 0, 0, 32'h3, 32'h4);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] sf;
      logic [31:0] df;
      sf = $urandom;
      df = $urandom;
      if (i % 7 == 0) sf = $urandom % 64;
      if (i % 11 == 0) df = 32'hFFFF_FFFF - ($urandom % 64);
      drive($urandom % 2 == 1, $urandom, sf, df, ($urandom % 4) != 0,
            ($urandom % 5) == 0, $urandom, $urandom);
    end
    drive(0, 32'h0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0);
    repeat (2) @(posedge clk);
    #3;
    finish_run();
  end
endmodule